// File: doc/BRIEF.md
# Duplicate-Merging Miss Request Queue

This block sits between a texture cache's miss detection and the memory that fills it. Each cycle up to four lanes can present the word address of a texel that missed. The block turns each one into a block address, with eight words to a block. It keeps one entry for every distinct block that has been asked for and not yet returned. It sends those block addresses to memory one at a time, oldest first. A lane whose block is already held, whether still waiting to be sent or already sent, is absorbed into the existing entry and creates no new traffic.

Memory answers in the order it was asked. Each answer retires the oldest sent entry. One cycle later the block address and its eight data words appear on a completion port for a single cycle, so every requester that merged into that block can pick up its data from the one return. When the lanes of a cycle would need more free entries than remain, the block stalls the miss source and takes nothing from that cycle. A cycle made only of duplicates never stalls.

Issue control is a two-state machine. In `ISS_IDLE` nothing is waiting to be sent. In `ISS_SEND` the request strobe is raised for the oldest unsent entry. `ISS_IDLE -> ISS_SEND` is taken when new blocks are accepted. `ISS_SEND -> ISS_IDLE` is taken when the last unsent entry is handed over and nothing new arrives in that cycle. Every other case holds the current state.

Top module: `miss_merge_queue`

## Requirements
- R1: After reset the queue is empty, `mem_req_valid`, `done_valid` and `miss_stall` are low.
- R2: A lane's block address is its word address shifted right by 3, so word addresses that differ only in bits [2:0] name the same block.
- R3: Every distinct accepted block address is presented on `mem_req_addr` exactly once, in acceptance order, with lower lane numbers first within a cycle.
- R4: A lane whose block matches an entry that is accepted but not yet sent creates no new entry and no new request.
- R5: A lane whose block matches an entry that was sent but has not returned creates no new request. Once that entry has retired, the same block is requested again.
- R6: Among lanes valid in one cycle with the same block, only the lowest-numbered lane can create an entry. An invalid lane is never considered.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address on the next cycle.
- R8: A cycle with `mem_rsp_valid` high, while a sent entry exists, retires the oldest sent entry. In the next cycle `done_valid` is high for one cycle, with that entry's block in `done_addr` and the response words unchanged in `done_data`.
- R9: `miss_stall` is high when the number of distinct new blocks among the valid lanes exceeds the free entries. In a stalled cycle no lane is taken.
- R10: A cycle whose valid lanes are all duplicates is accepted without a stall even when every entry is occupied.
- R11: The queue holds exactly `DEPTH` (32) distinct blocks; it never holds more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | LANES (4) | Per-lane miss present |
| miss_addr | input | LANES*ADDR_W (128) | Per-lane texel word address, lane 0 in the low bits |
| miss_stall | output | 1 | Cycle's lanes not taken; source must hold them |
| mem_req_valid | output | 1 | Block request to memory pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | BLK_W (29) | Requested block address |
| mem_rsp_valid | input | 1 | In-order block data return |
| mem_rsp_data | input | BLK_WORDS*WORD_W (256) | Returned block, word 0 in the low bits |
| done_valid | output | 1 | One-cycle completion strobe |
| done_addr | output | BLK_W (29) | Completed block address |
| done_data | output | BLK_WORDS*WORD_W (256) | Completed block data |

## Verification
The bound checker watches, on every cycle, that a request held against back-pressure keeps its address, that a response always produces a completion one cycle later, that a stalled cycle does not grow the occupancy, that an all-duplicate cycle is never stalled, and that occupancy never passes the depth. Properties cannot show that each block is fetched only once, in order, and that merged lanes never reach memory. The scoreboard shows this by comparing every issued address, and every completion with its data, against a model of the held blocks. The scenarios cover duplicates of unsent entries, duplicates of entries already in flight, duplicates inside one cycle, and a completely full queue.

// File: rtl/mmq_pkg.sv
package mmq_pkg;

    typedef enum logic [0:0] {
        ISS_IDLE = 1'b0,
        ISS_SEND = 1'b1
    } iss_state_e;

endpackage

// File: rtl/mmq_match.sv
// Classifies each lane as a new block or a duplicate: a lane is new when it
// is valid, hits no occupied entry and repeats no lower valid lane.
module mmq_match #(
    parameter int LANES = 4,
    parameter int BLK_W = 29,
    parameter int DEPTH = 32,
    parameter int NCW   = 3
) (
    input  logic [DEPTH*BLK_W-1:0] ent_addr,
    input  logic [DEPTH-1:0]       ent_occ,
    input  logic [LANES-1:0]       lane_vld,
    input  logic [LANES*BLK_W-1:0] lane_blk,
    output logic [LANES-1:0]       lane_new,
    output logic [NCW-1:0]         new_cnt
);

    logic [DEPTH-1:0] q_eq [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic early_dup;

        for (genvar k = 0; k < DEPTH; k++) begin : g_ent
            assign q_eq[i][k] = ent_occ[k] &&
                (ent_addr[k*BLK_W +: BLK_W] == lane_blk[i*BLK_W +: BLK_W]);
        end

        always_comb begin
            early_dup = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (lane_vld[j] &&
                    (lane_blk[j*BLK_W +: BLK_W] == lane_blk[i*BLK_W +: BLK_W])) begin
                    early_dup = 1'b1;
                end
            end
        end

        assign lane_new[i] = lane_vld[i] && !(|q_eq[i]) && !early_dup;
    end

    always_comb begin
        new_cnt = '0;
        for (int i = 0; i < LANES; i++) begin
            new_cnt = new_cnt + NCW'(lane_new[i]);
        end
    end

endmodule

// File: rtl/mmq_store.sv
// Circular entry array with three pointers: head (oldest outstanding),
// iss (oldest unsent) and tail (next free). DEPTH must be a power of two.
module mmq_store #(
    parameter int DEPTH = 32,
    parameter int BLK_W = 29,
    parameter int LANES = 4,
    parameter int PTR_W = 5,
    parameter int CNT_W = 6,
    parameter int NCW   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enq_en,
    input  logic [LANES-1:0]       lane_new,
    input  logic [LANES*BLK_W-1:0] lane_blk,
    input  logic                   iss_fire,
    input  logic                   rsp_fire,
    output logic [DEPTH*BLK_W-1:0] ent_addr,
    output logic [DEPTH-1:0]       ent_occ,
    output logic [CNT_W-1:0]       occ_cnt,
    output logic [CNT_W-1:0]       pend_cnt,
    output logic [CNT_W-1:0]       infl_cnt,
    output logic [BLK_W-1:0]       iss_addr,
    output logic [BLK_W-1:0]       head_addr
);

    logic [BLK_W-1:0] mem_q [DEPTH];
    logic [PTR_W:0]   head_q, iss_q, tail_q;
    logic [PTR_W-1:0] widx [LANES];
    logic [NCW-1:0]   acc;
    logic [NCW-1:0]   enq_total;

    // Write slot of each new lane: tail plus the new lanes below it.
    always_comb begin
        acc = '0;
        for (int i = 0; i < LANES; i++) begin
            widx[i] = tail_q[PTR_W-1:0] + PTR_W'(acc);
            acc     = acc + NCW'(lane_new[i]);
        end
        enq_total = enq_en ? acc : '0;
    end

    always_ff @(posedge clk) begin
        if (enq_en) begin
            for (int i = 0; i < LANES; i++) begin
                if (lane_new[i]) begin
                    mem_q[widx[i]] <= lane_blk[i*BLK_W +: BLK_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            iss_q  <= '0;
            tail_q <= '0;
        end else begin
            tail_q <= tail_q + (PTR_W+1)'(enq_total);
            iss_q  <= iss_q  + (PTR_W+1)'(iss_fire);
            head_q <= head_q + (PTR_W+1)'(rsp_fire);
        end
    end

    assign occ_cnt   = CNT_W'(tail_q - head_q);
    assign pend_cnt  = CNT_W'(tail_q - iss_q);
    assign infl_cnt  = CNT_W'(iss_q - head_q);
    assign iss_addr  = mem_q[iss_q[PTR_W-1:0]];
    assign head_addr = mem_q[head_q[PTR_W-1:0]];

    for (genvar k = 0; k < DEPTH; k++) begin : g_occ
        logic [PTR_W-1:0] rel;
        assign rel                     = PTR_W'(k) - head_q[PTR_W-1:0];
        assign ent_occ[k]              = CNT_W'(rel) < occ_cnt;
        assign ent_addr[k*BLK_W +: BLK_W] = mem_q[k];
    end

endmodule

// File: rtl/mmq_issue_fsm.sv
module mmq_issue_fsm
    import mmq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int NCW   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] pend_cnt,
    input  logic [NCW-1:0]   enq_n,
    input  logic             req_ready,
    output logic             req_valid,
    output logic             iss_fire
);

    iss_state_e       state_q, state_d;
    logic [CNT_W-1:0] pend_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ISS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_left = pend_cnt - CNT_W'(iss_fire) + CNT_W'(enq_n);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ISS_IDLE: state_d = (enq_n != '0) ? ISS_SEND : ISS_IDLE;
            ISS_SEND: state_d = (pend_left != '0) ? ISS_SEND : ISS_IDLE;
            default:  state_d = ISS_IDLE;
        endcase
    end

    always_comb begin
        req_valid = (state_q == ISS_SEND);
        iss_fire  = req_valid && req_ready;
    end

endmodule

// File: rtl/miss_merge_queue.sv
module miss_merge_queue #(
    parameter int LANES     = 4,
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 8,
    parameter int DEPTH     = 32,
    localparam int OFF_W    = $clog2(BLK_WORDS),
    localparam int BLK_W    = ADDR_W - OFF_W,
    localparam int DATA_W   = BLK_WORDS * WORD_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        miss_valid,
    input  logic [LANES*ADDR_W-1:0] miss_addr,
    output logic                    miss_stall,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [BLK_W-1:0]        mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [DATA_W-1:0]       mem_rsp_data,
    output logic                    done_valid,
    output logic [BLK_W-1:0]        done_addr,
    output logic [DATA_W-1:0]       done_data
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam int NCW   = $clog2(LANES + 1);

    logic [LANES*BLK_W-1:0] lane_blk;
    logic [LANES-1:0]       lane_new;
    logic [NCW-1:0]         new_cnt;
    logic [NCW-1:0]         enq_n;
    logic [DEPTH*BLK_W-1:0] ent_addr;
    logic [DEPTH-1:0]       ent_occ;
    logic [CNT_W-1:0]       occ_cnt, pend_cnt, infl_cnt, free_cnt;
    logic [BLK_W-1:0]       head_addr;
    logic                   accept, iss_fire, rsp_fire;

    for (genvar i = 0; i < LANES; i++) begin : g_blk
        assign lane_blk[i*BLK_W +: BLK_W] = miss_addr[i*ADDR_W + OFF_W +: BLK_W];
    end

    assign free_cnt   = CNT_W'(DEPTH) - occ_cnt;
    assign miss_stall = (|miss_valid) && (CNT_W'(new_cnt) > free_cnt);
    assign accept     = !miss_stall;
    assign enq_n      = accept ? new_cnt : '0;
    assign rsp_fire   = mem_rsp_valid && (infl_cnt != '0);

    mmq_match #(
        .LANES(LANES), .BLK_W(BLK_W), .DEPTH(DEPTH), .NCW(NCW)
    ) u_match (
        .ent_addr (ent_addr),
        .ent_occ  (ent_occ),
        .lane_vld (miss_valid),
        .lane_blk (lane_blk),
        .lane_new (lane_new),
        .new_cnt  (new_cnt)
    );

    mmq_store #(
        .DEPTH(DEPTH), .BLK_W(BLK_W), .LANES(LANES),
        .PTR_W(PTR_W), .CNT_W(CNT_W), .NCW(NCW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_en    (accept),
        .lane_new  (lane_new),
        .lane_blk  (lane_blk),
        .iss_fire  (iss_fire),
        .rsp_fire  (rsp_fire),
        .ent_addr  (ent_addr),
        .ent_occ   (ent_occ),
        .occ_cnt   (occ_cnt),
        .pend_cnt  (pend_cnt),
        .infl_cnt  (infl_cnt),
        .iss_addr  (mem_req_addr),
        .head_addr (head_addr)
    );

    mmq_issue_fsm #(
        .CNT_W(CNT_W), .NCW(NCW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend_cnt  (pend_cnt),
        .enq_n     (enq_n),
        .req_ready (mem_req_ready),
        .req_valid (mem_req_valid),
        .iss_fire  (iss_fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_addr  <= '0;
            done_data  <= '0;
        end else begin
            done_valid <= rsp_fire;
            if (rsp_fire) begin
                done_addr <= head_addr;
                done_data <= mem_rsp_data;
            end
        end
    end

endmodule

// File: rtl/mmq_chk.sv
module mmq_chk #(
    parameter int LANES = 4,
    parameter int BLK_W = 29,
    parameter int DEPTH = 32,
    parameter int CNT_W = 6,
    parameter int NCW   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LANES-1:0] miss_valid,
    input logic             miss_stall,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [BLK_W-1:0] mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             done_valid,
    input logic [CNT_W-1:0] occ_cnt,
    input logic [CNT_W-1:0] infl_cnt,
    input logic [NCW-1:0]   new_cnt
);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_cnt == '0) |-> !mem_req_valid);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_rsp_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && infl_cnt != '0) |=> done_valid);

    p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(mem_rsp_valid));

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_stall |=> (occ_cnt <= $past(occ_cnt)));

    p_dup_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((|miss_valid) && new_cnt == '0) |-> !miss_stall);

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

endmodule

bind miss_merge_queue mmq_chk #(
    .LANES(LANES), .BLK_W(BLK_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .NCW(NCW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_stall    (miss_stall),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .done_valid    (done_valid),
    .occ_cnt       (occ_cnt),
    .infl_cnt      (infl_cnt),
    .new_cnt       (new_cnt)
);

// File: tb/miss_merge_queue_tb_top.sv
`timescale 1ns/1ps
module miss_merge_queue_tb_top;

    localparam int LANES  = 4;
    localparam int ADDR_W = 32;
    localparam int BLK_W  = 29;
    localparam int DATA_W = 256;
    localparam int DEPTH  = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [LANES-1:0]        miss_valid = '0;
    logic [LANES*ADDR_W-1:0] miss_addr = '0;
    logic                    miss_stall;
    logic                    mem_req_valid;
    logic                    mem_req_ready = 1'b0;
    logic [BLK_W-1:0]        mem_req_addr;
    logic                    mem_rsp_valid = 1'b0;
    logic [DATA_W-1:0]       mem_rsp_data = '0;
    logic                    done_valid;
    logic [BLK_W-1:0]        done_addr;
    logic [DATA_W-1:0]       done_data;

    always #2.5 clk = ~clk;

    miss_merge_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_stall(miss_stall),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done_valid(done_valid), .done_addr(done_addr), .done_data(done_data)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [BLK_W-1:0] model_q[$];    // blocks held by the queue
    logic [BLK_W-1:0] exp_iss_q[$];  // expected issue order
    logic [BLK_W-1:0] exp_done_q[$]; // expected completions
    logic [BLK_W-1:0] rsp_q[$];      // fired, awaiting return
    int               due_q[$];
    int               rdy_mode = 0;  // 0 always, 1 never, 2 alternate
    int               mem_lat  = 4;
    int               cyc      = 0;
    int               n_fired  = 0;

    task automatic chk(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    function automatic logic [DATA_W-1:0] blk_data(input logic [BLK_W-1:0] b);
        logic [DATA_W-1:0] d;
        for (int w = 0; w < 8; w++) d[w*32 +: 32] = {b, 3'(w)} ^ 32'hC35A_0000;
        return d;
    endfunction

    function automatic bit held(input logic [BLK_W-1:0] b);
        foreach (model_q[k]) if (model_q[k] == b) return 1;
        return 0;
    endfunction

    // Driver: presents one cycle of lanes, predicts stall and new blocks.
    task automatic send(input logic [3:0] v, input logic [31:0] a0, input logic [31:0] a1,
                        input logic [31:0] a2, input logic [31:0] a3, input string tag,
                        output bit stalled);
        logic [31:0]      a [4];
        logic [BLK_W-1:0] nb [$];
        bit               exp_stall;
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        @(negedge clk);
        miss_valid = v;
        miss_addr  = {a3, a2, a1, a0};
        #1;
        for (int i = 0; i < 4; i++) begin
            logic [BLK_W-1:0] b;
            bit dup;
            b = a[i][31:3];
            dup = held(b);
            foreach (nb[k]) if (nb[k] == b) dup = 1;
            if (v[i] && !dup) nb.push_back(b);
        end
        exp_stall = (v != 0) && (nb.size() > DEPTH - model_q.size());
        chk(miss_stall == exp_stall, tag,
            $sformatf("stall act=%0b exp=%0b", miss_stall, exp_stall));
        stalled = miss_stall;
        if (!miss_stall) begin
            foreach (nb[k]) begin
                model_q.push_back(nb[k]);
                exp_iss_q.push_back(nb[k]);
            end
        end
        @(posedge clk);
        #1;
        miss_valid = '0;
    endtask

    // Memory model and issue monitor.
    initial begin
        bit               rsp_prev = 0;
        bit               hold_pend = 0;
        logic [BLK_W-1:0] hold_addr = '0;
        forever begin
            @(negedge clk);
            if (rsp_prev) void'(model_q.pop_front());
            rsp_prev      = 0;
            mem_rsp_valid = 1'b0;
            cyc++;
            if (rsp_q.size() > 0 && due_q[0] <= cyc) begin
                logic [BLK_W-1:0] b;
                b = rsp_q.pop_front();
                void'(due_q.pop_front());
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = blk_data(b);
                exp_done_q.push_back(b);
                rsp_prev = 1;
            end
            mem_req_ready = (rdy_mode == 0) || (rdy_mode == 2 && cyc[0]);
            #1;
            if (hold_pend) begin
                chk(mem_req_valid && mem_req_addr == hold_addr, "R7",
                    $sformatf("held req act=%0b/%h exp=1/%h", mem_req_valid, mem_req_addr, hold_addr));
                hold_pend = 0;
            end
            if (mem_req_valid) begin
                if (mem_req_ready) begin
                    if (exp_iss_q.size() == 0) begin
                        chk(0, "R3", $sformatf("issue act=%h exp=none", mem_req_addr));
                    end else begin
                        logic [BLK_W-1:0] e;
                        e = exp_iss_q.pop_front();
                        chk(mem_req_addr == e, "R3", $sformatf("issue act=%h exp=%h", mem_req_addr, e));
                    end
                    rsp_q.push_back(mem_req_addr);
                    due_q.push_back(cyc + mem_lat);
                    n_fired++;
                end else begin
                    hold_pend = 1;
                    hold_addr = mem_req_addr;
                end
            end
        end
    end

    // Completion monitor.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (done_valid) begin
                if (exp_done_q.size() == 0) begin
                    chk(0, "R8", $sformatf("done act=%h exp=none", done_addr));
                end else begin
                    logic [BLK_W-1:0] e;
                    e = exp_done_q.pop_front();
                    chk(done_addr == e && done_data == blk_data(e), "R8",
                        $sformatf("done act=%h exp=%h", done_addr, e));
                end
            end
        end
    end

    task automatic drain(input string tag);
        for (int i = 0; i < 3000; i++) begin
            if (model_q.size() == 0 && exp_done_q.size() == 0 && rsp_q.size() == 0) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        chk(model_q.size() == 0 && exp_iss_q.size() == 0, tag,
            $sformatf("left held=%0d unissued=%0d exp=0/0", model_q.size(), exp_iss_q.size()));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", "run hung act=timeout exp=done");
        finish_run();
    end

    initial begin
        bit st;
        int f0;
        logic [15:0] lfsr = 16'hACE1;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #3;
        chk(!mem_req_valid && !done_valid && !miss_stall, "R1",
            $sformatf("reset act=%0b%0b%0b exp=000", mem_req_valid, done_valid, miss_stall));

        // R2 / R8: one miss, full round trip
        rdy_mode = 0; mem_lat = 4;
        send(4'b0001, 32'h1000_0005, 0, 0, 0, "R2", st);
        drain("R8");

        // R2 / R6: words of the same block in one cycle
        send(4'b1111, 32'h40, 32'h41, 32'h47, 32'h48, "R2", st);
        drain("R2");

        // R6: invalid lane ignored, later duplicate dropped
        send(4'b1011, 32'h100, 32'h208, 32'h300, 32'h105, "R6", st);
        drain("R6");

        // R4: duplicate of an unsent entry
        rdy_mode = 1;
        send(4'b0001, 32'h800, 0, 0, 0, "R4", st);
        send(4'b0001, 32'h803, 0, 0, 0, "R4", st);
        send(4'b0001, 32'h900, 0, 0, 0, "R4", st);
        repeat (3) @(negedge clk);
        rdy_mode = 0;
        drain("R4");

        // R5: duplicate of an in-flight entry, then refetch after retire
        mem_lat = 40;
        f0 = n_fired;
        send(4'b0001, 32'h2000, 0, 0, 0, "R5", st);
        repeat (10) @(negedge clk);
        send(4'b0010, 0, 32'h2006, 0, 0, "R5", st);
        repeat (5) @(negedge clk);
        chk(n_fired == f0 + 1, "R5", $sformatf("fired act=%0d exp=%0d", n_fired - f0, 1));
        drain("R5");
        send(4'b0001, 32'h2001, 0, 0, 0, "R5", st);
        drain("R5");
        chk(n_fired == f0 + 2, "R5", $sformatf("refetch act=%0d exp=%0d", n_fired - f0, 2));

        // R11 / R9 / R10: fill the queue
        rdy_mode = 1; mem_lat = 3;
        for (int i = 0; i < DEPTH; i++) begin
            send(4'b0001, 32'h8000 + 32'(i) * 8, 0, 0, 0, "R11", st);
            chk(!st, "R11", $sformatf("entry %0d stall act=%0b exp=0", i, st));
        end
        send(4'b0001, 32'h9000, 0, 0, 0, "R9", st);
        chk(st, "R9", $sformatf("full stall act=%0b exp=1", st));
        send(4'b0100, 0, 0, 32'h802A, 0, "R10", st);
        chk(!st, "R10", $sformatf("dup stall act=%0b exp=0", st));
        send(4'b1111, 32'h8008, 32'h9100, 32'h8010, 32'h9200, "R9", st);
        chk(st, "R9", $sformatf("mixed stall act=%0b exp=1", st));
        rdy_mode = 2;
        drain("R9");

        // R3: dense traffic with overlap between lanes and in-flight blocks
        rdy_mode = 2; mem_lat = 6;
        for (int n = 0; n < 40; n++) begin
            logic [31:0] a [4];
            for (int i = 0; i < 4; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                a[i] = {25'h0, lfsr[3:0], lfsr[6:4]};
            end
            send(lfsr[11:8] | 4'b0001, a[0], a[1], a[2], a[3], "R3", st);
        end
        drain("R3");

        finish_run();
    end

endmodule